// File: doc/BRIEF.md
# ASCII Frame Longitudinal Checksum Verifier

This block sits behind a serial receiver and watches a text-mode frame as it arrives, one character per accepted transfer. It looks for the colon that opens a frame. It turns each pair of hexadecimal characters into a byte, high nibble first, and keeps a modulo-256 running sum of the bytes. The last byte pair before the carriage return is the received check value, so the block holds every decoded byte back by one position and leaves that final pair out of the sum.

When the line feed that closes the frame is accepted, the block pulses a done flag. It sets an ok flag if the received check byte plus the computed sum is zero modulo 256. It also presents the two's-complement of the sum as two uppercase ASCII hex characters, which a transmitter can append to an outgoing frame. Malformed input gives a one-cycle error pulse instead, and the block drops the frame. A colon that arrives in the middle of a frame throws away the partial frame and starts a new one.

Top module: `ascii_lrc_checker`

## Requirements
- R1: After reset, frame_done, frame_err and lrc_ok are low, and lrc_hi_char and lrc_lo_char both read '0' (30H).
- R2: A frame starts when ':' (3AH) is accepted. The colon is not summed. Outside a frame, any character other than ':' is ignored and produces no pulse.
- R3: Each byte is carried as two hex characters, high nibble first. '0'-'9', 'A'-'F' and 'a'-'f' are all valid digits.
- R4: The computed value is the two's-complement of the modulo-256 sum of every decoded byte except the last one before CR. It is output as uppercase ASCII on lrc_hi_char (high nibble) and lrc_lo_char (low nibble). It updates together with frame_done and holds between frames. For example, the bytes 01H 03H 04H 01H 00H 01H give 'F','6'. A frame holding only the check pair gives '0','0'.
- R5: lrc_ok updates together with frame_done. It is high exactly when the last byte plus the sum of the earlier bytes is 00H modulo 256, and it holds until the next completed frame.
- R6: frame_done is a one-cycle pulse in the cycle after the LF (0AH) that follows CR (0DH) is accepted. It stays low on every other character.
- R7: A character in a frame body that is not a hex digit, CR or ':' raises a one-cycle frame_err pulse in the next cycle and drops the frame, so a later CR LF gives no frame_done. lrc_ok and the LRC characters keep their values.
- R8: CR that follows an odd number of hex characters raises frame_err.
- R9: After CR, any character other than LF or ':' raises frame_err.
- R10: ':' accepted in the body, or after CR, restarts the frame without an error. The new frame's result depends only on the bytes that follow that colon.
- R11: CR with no complete byte pair since ':' raises frame_err.
- R12: in_ready is always high. A character with in_valid low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Character on in_char is offered |
| in_char | input | 8 | ASCII character |
| in_ready | output | 1 | Block accepts a character (always high) |
| frame_done | output | 1 | One-cycle pulse: a frame closed with CR LF |
| frame_err | output | 1 | One-cycle pulse: a framing error dropped the frame |
| lrc_ok | output | 1 | Result of the check for the last completed frame |
| lrc_hi_char | output | 8 | Computed LRC, high nibble as an uppercase ASCII hex digit |
| lrc_lo_char | output | 8 | Computed LRC, low nibble as an uppercase ASCII hex digit |

## Verification
The bench targets four corners. First, the exclusion of the trailing check pair: a design that summed it would report every good frame as bad and output the wrong LRC characters. Second, lowercase digits: a design with no lowercase decode would flag an error on a valid frame. Third, odd digit counts, a bare CR and CR followed by a stray character: a lax design would pulse done on a broken frame. Fourth, a colon arriving in the middle of a frame: a design that failed to clear its sum or its pending nibble would carry stale bytes into the next result. Random frames of one to eleven bytes, with mixed case, corrupted check bytes and idle gaps, are checked against a sum computed in the bench.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  localparam int CHAR_W = 8;
  localparam int LRC_W  = 8;
  localparam int NIB_W  = 4;

  localparam logic [CHAR_W-1:0] CH_COLON = 8'h3A;
  localparam logic [CHAR_W-1:0] CH_CR    = 8'h0D;
  localparam logic [CHAR_W-1:0] CH_LF    = 8'h0A;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BODY,
    ST_WAIT_LF
  } lrc_state_e;

  typedef enum logic [2:0] {
    CLS_HEX,
    CLS_START,
    CLS_CR,
    CLS_LF,
    CLS_OTHER
  } char_class_e;
endpackage

// File: rtl/lrc_char_decode.sv
module lrc_char_decode
  import lrc_pkg::*;
(
  input  logic [CHAR_W-1:0] ch_i,
  output char_class_e       cls_o,
  output logic [NIB_W-1:0]  nib_o
);
  logic is_digit;
  logic is_upper;
  logic is_lower;

  always_comb begin
    is_digit = (ch_i >= 8'h30) && (ch_i <= 8'h39);
    is_upper = (ch_i >= 8'h41) && (ch_i <= 8'h46);
    is_lower = (ch_i >= 8'h61) && (ch_i <= 8'h66);
    // letters of either case keep 1..6 in the low nibble; adding 9 yields A..F
    nib_o = is_digit ? ch_i[NIB_W-1:0] : ch_i[NIB_W-1:0] + 4'd9;
    if (is_digit || is_upper || is_lower) cls_o = CLS_HEX;
    else if (ch_i == CH_COLON)            cls_o = CLS_START;
    else if (ch_i == CH_CR)               cls_o = CLS_CR;
    else if (ch_i == CH_LF)               cls_o = CLS_LF;
    else                                  cls_o = CLS_OTHER;
  end
endmodule

// File: rtl/lrc_accum.sv
module lrc_accum
  import lrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             byte_en_i,
  input  logic [LRC_W-1:0] byte_i,
  output logic [LRC_W-1:0] sum_o,
  output logic [LRC_W-1:0] pend_o,
  output logic             pend_v_o
);
  logic [LRC_W-1:0] sum_q, sum_d;
  logic [LRC_W-1:0] pend_q, pend_d;
  logic             pv_q, pv_d;

  always_comb begin
    sum_d  = sum_q;
    pend_d = pend_q;
    pv_d   = pv_q;
    if (clr_i) begin
      sum_d  = '0;
      pend_d = '0;
      pv_d   = 1'b0;
    end else if (byte_en_i) begin
      // the byte held back is summed only once a newer byte proves it is not the check
      if (pv_q) sum_d = sum_q + pend_q;
      pend_d = byte_i;
      pv_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      pend_q <= '0;
      pv_q   <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
    end
  end

  assign sum_o    = sum_q;
  assign pend_o   = pend_q;
  assign pend_v_o = pv_q;
endmodule

// File: rtl/lrc_hex_encode.sv
module lrc_hex_encode
  import lrc_pkg::*;
#(
  parameter int VAL_W = LRC_W,
  localparam int NIBS = VAL_W / NIB_W
) (
  input  logic [VAL_W-1:0]            val_i,
  output logic [NIBS-1:0][CHAR_W-1:0] chars_o
);
  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    logic [NIB_W-1:0] nib;
    assign nib = val_i[g*NIB_W +: NIB_W];
    assign chars_o[g] = (nib < 4'd10) ? {4'h3, nib} : (8'h37 + {4'h0, nib});
  end
endmodule

// File: rtl/ascii_lrc_checker.sv
module ascii_lrc_checker
  import lrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  output logic              in_ready,
  output logic              frame_done,
  output logic              frame_err,
  output logic              lrc_ok,
  output logic [CHAR_W-1:0] lrc_hi_char,
  output logic [CHAR_W-1:0] lrc_lo_char
);
  localparam int NIBS = LRC_W / NIB_W;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  char_class_e      cls;
  logic [NIB_W-1:0] nib;

  lrc_char_decode u_dec (
    .ch_i  (in_char),
    .cls_o (cls),
    .nib_o (nib)
  );

  logic             accept;
  logic             acc_clr, acc_en;
  logic [LRC_W-1:0] sum, pend;
  logic             pend_v;

  lrc_state_e       state_q, state_d;
  logic             phase_q, phase_d;
  logic [NIB_W-1:0] hi_q, hi_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             ok_q, ok_d;
  logic [LRC_W-1:0] lrc_q, lrc_d;
  logic [LRC_W-1:0] check_total;

  assign in_ready    = 1'b1;
  assign accept      = in_valid && in_ready;
  assign check_total = pend + sum;

  lrc_accum u_acc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (acc_clr),
    .byte_en_i (acc_en),
    .byte_i    ({hi_q, nib}),
    .sum_o     (sum),
    .pend_o    (pend),
    .pend_v_o  (pend_v)
  );

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    hi_d    = hi_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    ok_d    = ok_q;
    lrc_d   = lrc_q;
    acc_clr = 1'b0;
    acc_en  = 1'b0;
    if (accept) begin
      if (cls == CLS_START) begin
        acc_clr = 1'b1;
        phase_d = 1'b0;
        state_d = ST_BODY;
      end else begin
        unique case (state_q)
          ST_BODY: begin
            if (cls == CLS_HEX) begin
              if (!phase_q) begin
                hi_d    = nib;
                phase_d = 1'b1;
              end else begin
                acc_en  = 1'b1;
                phase_d = 1'b0;
              end
            end else if (cls == CLS_CR && !phase_q && pend_v) begin
              state_d = ST_WAIT_LF;
            end else begin
              err_d   = 1'b1;
              phase_d = 1'b0;
              state_d = ST_IDLE;
            end
          end
          ST_WAIT_LF: begin
            if (cls == CLS_LF) begin
              done_d = 1'b1;
              ok_d   = (check_total == '0);
              lrc_d  = -sum;
            end else begin
              err_d = 1'b1;
            end
            state_d = ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      hi_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ok_q    <= 1'b0;
      lrc_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      hi_q    <= hi_d;
      done_q  <= done_d;
      err_q   <= err_d;
      ok_q    <= ok_d;
      lrc_q   <= lrc_d;
    end
  end

  logic [NIBS-1:0][CHAR_W-1:0] lrc_chars;

  lrc_hex_encode #(.VAL_W(LRC_W)) u_enc (
    .val_i   (lrc_q),
    .chars_o (lrc_chars)
  );

  assign frame_done  = done_q;
  assign frame_err   = err_q;
  assign lrc_ok      = ok_q;
  assign lrc_hi_char = lrc_chars[NIBS-1];
  assign lrc_lo_char = lrc_chars[0];
endmodule

module ascii_lrc_checker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_char,
  input logic       in_ready,
  input logic       frame_done,
  input logic       frame_err,
  input logic       lrc_ok,
  input logic [7:0] lrc_hi_char,
  input logic [7:0] lrc_lo_char
);
  // R12
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  // R6
  done_after_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(in_valid) && $past(in_char) == 8'h0A));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R7
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_err));

  // R12
  err_needs_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(in_valid));

  // R5
  ok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(lrc_ok));

  // R4
  lrc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable({lrc_hi_char, lrc_lo_char}));

  // R4
  lrc_upper_hex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lrc_hi_char >= 8'h30 && lrc_hi_char <= 8'h39) || (lrc_hi_char >= 8'h41 && lrc_hi_char <= 8'h46)) &&
    ((lrc_lo_char >= 8'h30 && lrc_lo_char <= 8'h39) || (lrc_lo_char >= 8'h41 && lrc_lo_char <= 8'h46)));
endmodule

bind ascii_lrc_checker ascii_lrc_checker_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_char     (in_char),
  .in_ready    (in_ready),
  .frame_done  (frame_done),
  .frame_err   (frame_err),
  .lrc_ok      (lrc_ok),
  .lrc_hi_char (lrc_hi_char),
  .lrc_lo_char (lrc_lo_char)
);

// File: tb/test_ascii_lrc_checker.sv
module test_ascii_lrc_checker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_char = 8'h00;
  logic       in_ready, frame_done, frame_err, lrc_ok;
  logic [7:0] lrc_hi_char, lrc_lo_char;

  int checks = 0;
  int fails = 0;
  bit rand_gaps = 1'b0;
  logic [7:0] fb [0:15];
  logic       exp_ok = 1'b0;
  logic [7:0] exp_lrc = 8'h00;

  always #4 clk = ~clk;

  ascii_lrc_checker i_ascii_lrc_checker (
    .clk, .rst_n, .in_valid, .in_char, .in_ready,
    .frame_done, .frame_err, .lrc_ok, .lrc_hi_char, .lrc_lo_char
  );

  function automatic logic [7:0] hexch(input logic [3:0] n, input bit lower);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    return (lower ? 8'h57 : 8'h37) + {4'h0, n};
  endfunction

  task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c);
    if (rand_gaps) begin
      int gap = $urandom % 3;
      repeat (gap) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
    @(negedge clk);
    in_valid = 1'b0;
    in_char  = 8'h47;
  endtask

  task automatic quiet(input string tag);
    chk(!frame_done, tag, frame_done, 0);
    chk(!frame_err, tag, frame_err, 0);
  endtask

  task automatic check_held(input string tag);
    chk(lrc_ok == exp_ok, tag, lrc_ok, exp_ok);
    chk(lrc_hi_char == hexch(exp_lrc[7:4], 0) && lrc_lo_char == hexch(exp_lrc[3:0], 0), tag,
        {lrc_hi_char, lrc_lo_char}, {hexch(exp_lrc[7:4], 0), hexch(exp_lrc[3:0], 0)});
  endtask

  // fb[0..n-1] are summed, fb[n] is the check byte
  task automatic send_frame(input int n, input bit lower, input string tag);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < n; i++) s = s + fb[i];
    send(8'h3A);
    quiet({tag, " R2 colon"});
    for (int i = 0; i <= n; i++) begin
      send(hexch(fb[i][7:4], lower));
      quiet({tag, " R6 hi"});
      send(hexch(fb[i][3:0], lower));
      quiet({tag, " R6 lo"});
    end
    send(8'h0D);
    quiet({tag, " R6 cr"});
    send(8'h0A);
    exp_ok  = (8'(fb[n] + s) == 8'h00);
    exp_lrc = 8'(-s);
    chk(frame_done, {tag, " R6 done"}, frame_done, 1);
    chk(!frame_err, {tag, " R7 err"}, frame_err, 0);
    check_held({tag, " R4 R5 result"});
  endtask

  task automatic expect_err(input string tag);
    chk(frame_err, tag, frame_err, 1);
    chk(!frame_done, tag, frame_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!frame_done && !frame_err && !lrc_ok, "R1 flags", {frame_done, frame_err, lrc_ok}, 0);
    chk(lrc_hi_char == 8'h30 && lrc_lo_char == 8'h30, "R1 chars", {lrc_hi_char, lrc_lo_char}, 16'h3030);
    chk(in_ready, "R12 ready", in_ready, 1);

    // R2 junk outside a frame is ignored
    send(8'h41); quiet("R2 junk");
    send(8'h0D); quiet("R2 junk cr");
    send(8'h0A); quiet("R2 junk lf");

    // R4 R5 worked example, uppercase
    fb[0] = 8'h01; fb[1] = 8'h03; fb[2] = 8'h04; fb[3] = 8'h01; fb[4] = 8'h00; fb[5] = 8'h01; fb[6] = 8'hF6;
    send_frame(6, 0, "R4 example");
    chk(lrc_hi_char == 8'h46 && lrc_lo_char == 8'h36, "R4 F6", {lrc_hi_char, lrc_lo_char}, 16'h4636);
    chk(lrc_ok, "R5 example ok", lrc_ok, 1);

    // R3 lowercase digits
    send_frame(6, 1, "R3 lower");

    // R5 corrupted check byte
    fb[6] = 8'hF7;
    send_frame(6, 0, "R5 bad");
    chk(!lrc_ok, "R5 bad ok low", lrc_ok, 0);

    // R4 check pair only
    fb[0] = 8'h00;
    send_frame(0, 0, "R4 only check");

    // R7 non-hex in body, then CR LF gives nothing
    fb[0] = 8'h12; fb[1] = 8'hEE;
    send_frame(1, 0, "R7 setup");
    send(8'h3A); send(8'h31); send(8'h47);
    expect_err("R7 bad char");
    send(8'h0D); quiet("R7 after cr");
    send(8'h0A); quiet("R7 after lf");
    check_held("R7 held");

    // R8 odd digit count
    send(8'h3A); send(8'h31); send(8'h32); send(8'h33); send(8'h0D);
    expect_err("R8 odd");

    // R11 bare CR
    send(8'h3A); send(8'h0D);
    expect_err("R11 empty");

    // R9 CR then a stray character
    send(8'h3A); send(8'h31); send(8'h32); send(8'h0D); send(8'h58);
    expect_err("R9 stray");
    check_held("R9 held");

    // R10 colon after CR restarts cleanly
    send(8'h3A); send(8'h31); send(8'h32); send(8'h0D);
    fb[0] = 8'h01; fb[1] = 8'h02; fb[2] = 8'hFD;
    send_frame(2, 0, "R10 after cr");
    chk(lrc_ok && lrc_hi_char == 8'h46 && lrc_lo_char == 8'h44, "R10 FD", {lrc_ok, lrc_hi_char, lrc_lo_char}, 17'h14644);

    // R10 colon mid-body with pending nibble
    send(8'h3A); send(8'h46); send(8'h46); send(8'h46);
    fb[0] = 8'h10; fb[1] = 8'h20; fb[2] = 8'hD0;
    send_frame(2, 0, "R10 mid body");
    chk(lrc_ok, "R10 mid ok", lrc_ok, 1);

    // R12 characters with in_valid low are not taken
    send(8'h3A); send(8'h30);
    @(negedge clk); in_char = 8'h58; @(negedge clk); in_char = 8'h3A; @(negedge clk);
    quiet("R12 invalid");
    send(8'h41); send(8'h41); send(8'h41); send(8'h0D); send(8'h0A);
    exp_ok = 1'b0; exp_lrc = 8'hF6; // sum 0AH, check AAH
    chk(frame_done, "R12 done", frame_done, 1);
    check_held("R12 result");

    // random frames, R3 R4 R5
    rand_gaps = 1'b1;
    for (int f = 0; f < 40; f++) begin
      int n = $urandom % 11;
      logic [7:0] s = 8'h00;
      bit lower = 1'($urandom);
      for (int i = 0; i < n; i++) begin
        fb[i] = 8'($urandom);
        s = s + fb[i];
      end
      fb[n] = 8'(-s);
      if ($urandom % 2) fb[n] = fb[n] + 8'(1 + $urandom % 255);
      send_frame(n, lower, "R4 R5 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule